// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eight interrupt sources for a small processor sequencer and presents the winning source as a vector address with a valid flag. Six sources have active-low hardware request lines. Two are software sources with no line at all. Three of the hardware sources can be set to edge or level sensitivity. The others are always edge-sensitive.

Software reaches the block through a write port with three targets. The first is a write-action word that clears pending bits through its low byte and forces them through its high byte. The second is an enable mask. The third is a control word that holds the sensitivity bits and a nesting enable. When the sequencer takes an interrupt it pulses `ack`. This clears the latched pending bit and records the source as in service. `svc_done` retires the most recent service. With nesting off, nothing new is presented while any source is in service. With nesting on, only a source of strictly higher priority than the one in service is presented.

Sources are numbered 0 to 7, and a lower number means a higher priority. Source k has vector 0x000C + 4·k, so the sources use four-word slots up to 0x0028. Source 7 is the timer at 0x0028 and has the lowest priority. Sources 5 and 6 are the secondary serial port pair at 0x0020 and 0x0024. Sources 3 and 4 are software-only. Source 0 is the shared peripheral request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_vld` is 0 and `irq_vec` is 0. Nothing is pending, the mask is all zero, all configurable sources are level-sensitive, and nesting is off.
- R2: While `irq_vld` is 1, `irq_vec` equals 0x000C + 4·k for the presented source k. While `irq_vld` is 0, `irq_vec` is 0.
- R3: Among the sources that are enabled and pending, the lowest-numbered source is presented.
- R4: A write with `wr_sel`=1 loads the mask. Data bit 9−k enables source k, so bit 9 enables source 0 and bit 2 enables source 7. A disabled source is never presented, but its latched pending bit is kept and shows once the source is enabled.
- R5: An edge-sensitive source becomes pending on a falling edge of its line and stays pending after the line returns high. A write with `wr_sel`=2 sets sensitivity: data bit 0 controls source 6, bit 1 controls source 5 and bit 2 controls source 0, where 1 means edge and 0 means level. Sources 1, 2 and 7 are always edge-sensitive.
- R6: A level-sensitive source counts as pending only while its line is low. Its line is not latched.
- R7: A write with `wr_sel`=0 clears pending source k for each data bit k (0–7) and forces source k pending for each data bit k+8. When the same write both clears and forces a source, the clear wins.
- R8: Sources 3 and 4 become pending only through force bits 11 and 12. Input lines `req_n[3]` and `req_n[4]` have no effect.
- R9: Request lines pass through a two-flop synchronizer. A line sampled low at one rising edge is presented after the following rising edge, if it is enabled and allowed.
- R10: `ack` while `irq_vld` is 1 clears the latched pending bit of the presented source and marks it in service. `ack` while `irq_vld` is 0 has no effect.
- R11: With nesting off (control bit 4 = 0), `irq_vld` stays 0 while any source is in service.
- R12: With nesting on, a source is presented during service only if its number is lower than that of every source in service. `svc_done` retires the most recently acknowledged source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 8 | Active-low request lines, one per source (bits 3 and 4 unused) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 clear/force, 1 mask, 2 control, 3 none |
| wr_data | input | 16 | Write data |
| ack | input | 1 | Sequencer takes the presented interrupt |
| svc_done | input | 1 | Sequencer finished the innermost service routine |
| irq_vld | output | 1 | A vector is presented |
| irq_vec | output | 16 | Vector address of the presented source |

## Verification
A behavioural model predicts `irq_vld` and `irq_vec` on every clock, and the bench drives it through several input patterns. Single short pulses on edge lines separate latching from level following. A line held low through an acknowledge shows whether one edge produces exactly one service or a level source keeps reasserting. Forcing all eight sources at once and then retiring them one by one walks the whole priority order and every vector slot. Service sequences with nesting off and on, including a lower-priority force during a nested service, tell apart the blocking, preemption and stack-ordered retirement behaviours.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
    localparam int NSRC       = 8;
    localparam int SRC_W      = $clog2(NSRC);
    localparam int VEC_W      = 16;
    localparam int DATA_W     = 16;
    localparam int VEC_STRIDE = 4;
    localparam int MASK_TOP   = 9;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h000C;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [SRC_W-1:0] src_id_t;

    typedef enum logic [1:0] {
        SENS_NONE  = 2'd0,
        SENS_EDGE  = 2'd1,
        SENS_CFG   = 2'd2
    } sens_kind_t;

    typedef enum logic [1:0] {
        WR_FC   = 2'd0,
        WR_MASK = 2'd1,
        WR_CTRL = 2'd2
    } wr_target_t;

    typedef struct packed {
        logic       nest;
        logic [2:0] sense;
    } ctrl_t;

    typedef struct packed {
        logic    any;
        src_id_t id;
    } pick_t;

    function automatic sens_kind_t src_kind(input int k);
        case (k)
            0, 5, 6: return SENS_CFG;
            3, 4:    return SENS_NONE;
            default: return SENS_EDGE;
        endcase
    endfunction

    function automatic int cfg_bit(input int k);
        case (k)
            6:       return 0;
            5:       return 1;
            default: return 2;
        endcase
    endfunction

    function automatic pick_t lowest_set(input src_vec_t v);
        pick_t r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.any = 1'b1;
                r.id  = src_id_t'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input src_id_t id);
        return VEC_BASE + VEC_W'(id) * VEC_W'(VEC_STRIDE);
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] line_n,
    output logic [WIDTH-1:0] level_n,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain[0] <= line_n;
            for (int i = 1; i <= STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign level_n = chain[STAGES-1];
    assign fall    = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend
    import irq_vc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t edge_en,
    input  src_vec_t level_en,
    input  src_vec_t fall,
    input  src_vec_t level_n,
    input  src_vec_t force_set,
    input  src_vec_t clr,
    input  src_vec_t ack_bit,
    output src_vec_t eff
);
    src_vec_t pend_q;
    src_vec_t pend_d;
    src_vec_t edge_hit;

    assign edge_hit = fall & edge_en;
    assign pend_d   = (pend_q | edge_hit | force_set) & ~clr & ~ack_bit;
    assign eff      = pend_q | edge_hit | (~level_n & level_en);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R7
        clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
            clr[i] |=> !pend_q[i]);
        // R7
        force_sets_chk: assert property (@(posedge clk) disable iff (rst)
            force_set[i] && !clr[i] && !ack_bit[i] |=> pend_q[i]);
        // R10
        ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
            ack_bit[i] |=> !pend_q[i]);
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_vc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  src_vec_t         eff,
    input  src_vec_t         mask,
    input  logic             nest,
    input  logic             ack,
    input  logic             done,
    output logic             vld,
    output logic [VEC_W-1:0] vec,
    output src_vec_t         ack_bit
);
    src_vec_t in_svc_q;
    src_vec_t in_svc_d;
    pick_t    top;
    pick_t    svc;
    logic     allow;
    logic     take;

    assign top   = lowest_set(eff & mask);
    assign svc   = lowest_set(in_svc_q);
    assign allow = !svc.any || (nest && top.id < svc.id);
    assign vld   = top.any && allow;
    assign vec   = vld ? vec_of(top.id) : '0;
    assign take  = ack && vld;

    always_comb begin
        ack_bit  = '0;
        in_svc_d = in_svc_q;
        if (done && svc.any) in_svc_d[svc.id] = 1'b0;
        if (take) begin
            ack_bit[top.id]  = 1'b1;
            in_svc_d[top.id] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) in_svc_q <= '0;
        else     in_svc_q <= in_svc_d;
    end

    // R11
    no_nest_block_chk: assert property (@(posedge clk) disable iff (rst)
        !nest && (in_svc_q != '0) |-> !vld);
    // R2
    vec_slot_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> (vec[1:0] == 2'b00) && (vec >= VEC_BASE)
                && (vec <= VEC_BASE + VEC_W'((NSRC - 1) * VEC_STRIDE)));
    // R2
    vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> vec == '0);
    // R10
    take_records_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> in_svc_q != '0);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   req_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack,
    input  logic              svc_done,
    output logic              irq_vld,
    output logic [VEC_W-1:0]  irq_vec
);
    ctrl_t    ctrl_q;
    src_vec_t mask_q;
    src_vec_t mask_d;
    src_vec_t edge_en;
    src_vec_t level_en;
    src_vec_t level_n;
    src_vec_t fall;
    src_vec_t force_set;
    src_vec_t clr;
    src_vec_t ack_bit;
    src_vec_t eff;
    logic     fc_wr;

    assign fc_wr     = wr_en && (wr_sel == WR_FC);
    assign clr       = fc_wr ? wr_data[NSRC-1:0] : '0;
    assign force_set = fc_wr ? wr_data[2*NSRC-1:NSRC] : '0;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign mask_d[k] = wr_data[MASK_TOP-k];
        if (src_kind(k) == SENS_EDGE) begin : g_edge
            assign edge_en[k]  = 1'b1;
            assign level_en[k] = 1'b0;
        end else if (src_kind(k) == SENS_CFG) begin : g_cfg
            assign edge_en[k]  = ctrl_q.sense[cfg_bit(k)];
            assign level_en[k] = ~ctrl_q.sense[cfg_bit(k)];
        end else begin : g_soft
            assign edge_en[k]  = 1'b0;
            assign level_en[k] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == WR_MASK) mask_q <= mask_d;
            if (wr_sel == WR_CTRL) begin
                ctrl_q.sense <= wr_data[2:0];
                ctrl_q.nest  <= wr_data[4];
            end
        end
    end

    irq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_n  (req_n),
        .level_n (level_n),
        .fall    (fall)
    );

    irq_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .edge_en   (edge_en),
        .level_en  (level_en),
        .fall      (fall),
        .level_n   (level_n),
        .force_set (force_set),
        .clr       (clr),
        .ack_bit   (ack_bit),
        .eff       (eff)
    );

    irq_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .eff     (eff),
        .mask    (mask_q),
        .nest    (ctrl_q.nest),
        .ack     (ack),
        .done    (svc_done),
        .vld     (irq_vld),
        .vec     (irq_vec),
        .ack_bit (ack_bit)
    );

    // R4
    masked_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        irq_vld |-> mask_q[(irq_vec - VEC_BASE) >> 2]);
    // R8
    soft_no_line_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_en[3] | edge_en[4] | level_en[3] | level_en[4]) == 1'b0);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_n = 8'hFF;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        ack = 1'b0;
    logic        svc_done = 1'b0;
    logic        irq_vld;
    logic [15:0] irq_vec;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string tag = "R1";

    // model state
    logic [7:0] h0 = 8'hFF, h1 = 8'hFF, h2 = 8'hFF;
    bit   [7:0] mp = '0;
    bit   [7:0] mmask = '0;
    bit   [2:0] msense = '0;
    bit         mnest = 1'b0;
    int         stk[$];

    irq_vector_ctrl uut (
        .clk(clk), .rst(rst), .req_n(req_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack(ack), .svc_done(svc_done),
        .irq_vld(irq_vld), .irq_vec(irq_vec)
    );

    always #5 clk = ~clk;

    // 0 none, 1 edge, 2 level
    function automatic int kind_of(input int k);
        case (k)
            3, 4:    return 0;
            0:       return msense[2] ? 1 : 2;
            5:       return msense[1] ? 1 : 2;
            6:       return msense[0] ? 1 : 2;
            default: return 1;
        endcase
    endfunction

    function automatic bit [7:0] m_fall();
        bit [7:0] f;
        for (int k = 0; k < 8; k++) f[k] = (kind_of(k) == 1) && h2[k] && !h1[k];
        return f;
    endfunction

    function automatic void m_eval(output bit v, output int top);
        bit [7:0] f;
        bit [7:0] cand;
        f = m_fall();
        for (int k = 0; k < 8; k++)
            cand[k] = mmask[k] && (mp[k] || f[k] || (kind_of(k) == 2 && !h1[k]));
        v = 1'b0;
        top = 0;
        for (int k = 7; k >= 0; k--) if (cand[k]) top = k;
        if (cand != 0) begin
            if (stk.size() == 0) v = 1'b1;
            else if (mnest && top < stk[stk.size()-1]) v = 1'b1;
        end
    endfunction

    always @(posedge clk) begin
        bit v;
        int top;
        bit [7:0] f;
        cyc++;
        if (rst) begin
            h0 = 8'hFF; h1 = 8'hFF; h2 = 8'hFF;
            mp = '0; mmask = '0; msense = '0; mnest = 1'b0;
            stk.delete();
        end else begin
            m_eval(v, top);
            f = m_fall();
            if (wr_en && wr_sel == 2'd0) mp = (mp | f | wr_data[15:8]) & ~wr_data[7:0];
            else                         mp = mp | f;
            if (ack && v) mp[top] = 1'b0;
            if (svc_done && stk.size() > 0) void'(stk.pop_back());
            if (ack && v) stk.push_back(top);
            if (wr_en && wr_sel == 2'd1) for (int k = 0; k < 8; k++) mmask[k] = wr_data[9-k];
            if (wr_en && wr_sel == 2'd2) begin
                msense = wr_data[2:0];
                mnest  = wr_data[4];
            end
            h2 = h1; h1 = h0; h0 = req_n;
        end
    end

    always @(negedge clk) begin
        bit v;
        int top;
        logic [15:0] ev;
        if (!rst) begin
            m_eval(v, top);
            ev = v ? 16'(16'h000C + 4 * top) : 16'h0;
            checks++;
            if (irq_vld !== v || irq_vec !== ev) begin
                errors++;
                $display("FAIL %s: vld=%0b vec=%h expected vld=%0b vec=%h",
                         tag, irq_vld, irq_vec, v, ev);
            end
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_done();
        svc_done = 1'b1; tick(); svc_done = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tag = "R1"; tick(3);

        // R5: edge sources latch a pulse
        tag = "R5";
        wr(2'd1, 16'h03FC);
        wr(2'd2, 16'h0007);
        req_n[7] = 1'b0; tick(); req_n[7] = 1'b1; tick(4);
        do_ack(); tick(2); do_done(); tick(2);
        req_n[0] = 1'b0; tick(4); do_ack(); tick(3); do_done(); tick(3);
        req_n[0] = 1'b1; tick(3);

        // R9: synchronizer latency on configurable edge source 6
        tag = "R9";
        req_n[6] = 1'b0; tick(4); do_ack(); req_n[6] = 1'b1; tick(); do_done(); tick(3);

        // R3: all forced, drained in priority order
        tag = "R3";
        wr(2'd0, 16'hFF00);
        for (int i = 0; i < 8; i++) begin
            tick(); do_ack(); do_done();
        end
        tick(2);

        // R2: each vector slot alone
        tag = "R2";
        for (int k = 0; k < 8; k++) begin
            wr(2'd0, 16'(16'h0100 << k)); tick(); do_ack(); do_done();
        end
        tick(2);

        // R7: clear wins over force, clear removes a forced bit
        tag = "R7";
        wr(2'd0, 16'h8080); tick(2);
        wr(2'd0, 16'h0200); tick(2);
        wr(2'd0, 16'h0002); tick(2);

        // R8: software sources ignore lines, respond to force
        tag = "R8";
        req_n[3] = 1'b0; req_n[4] = 1'b0; tick(5);
        req_n[3] = 1'b1; req_n[4] = 1'b1; tick(3);
        wr(2'd0, 16'h1800); tick();
        do_ack(); do_done(); do_ack(); do_done(); tick(2);

        // R6: level source follows the line and re-asserts after service
        tag = "R6";
        wr(2'd2, 16'h0000);
        req_n[6] = 1'b0; tick(4); req_n[6] = 1'b1; tick(4);
        req_n[6] = 1'b0; tick(3); do_ack(); tick(2); do_done(); tick(2);
        req_n[6] = 1'b1; tick(4);

        // R4: masked edge stays latched, shown when enabled; bit 9 enables source 0
        tag = "R4";
        wr(2'd1, 16'h0000);
        req_n[1] = 1'b0; tick(); req_n[1] = 1'b1; tick(5);
        wr(2'd1, 16'h0100); tick(2); do_ack(); do_done();
        wr(2'd0, 16'h0100); tick(2);
        wr(2'd1, 16'h0200); tick(2); do_ack(); do_done(); tick(2);

        // R10: ack without a valid vector is ignored
        tag = "R10";
        wr(2'd1, 16'h03FC);
        do_ack(); tick(2);
        wr(2'd0, 16'h0400); tick(); do_ack(); tick(2); do_done(); tick(2);

        // R11: no nesting blocks higher source during service
        tag = "R11";
        wr(2'd2, 16'h0007);
        wr(2'd0, 16'h8000); tick(); do_ack();
        wr(2'd0, 16'h0200); tick(3);
        do_done(); tick(2); do_ack(); do_done(); tick(2);

        // R12: nesting preempts only for higher priority, stack order retire
        tag = "R12";
        wr(2'd2, 16'h0017);
        wr(2'd0, 16'h8000); tick(); do_ack();
        wr(2'd0, 16'h0200); tick(); do_ack();
        wr(2'd0, 16'h1000); tick(3);
        do_done(); tick(2); do_ack(); tick(2);
        do_done(); do_done(); tick(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule